// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Operand Preparation

This block is the purely combinational execute stage of a 32-bit load/store integer pipeline. Each cycle it receives a decoded operation code, two register operands (`rs_i`, `rt_i`) and a 16-bit immediate field. It returns a 32-bit result and a signed-overflow flag in the same cycle.

Before any operation runs, the block selects the second operand. Register forms use `rt_i` directly. Immediate forms widen the 16-bit field to 32 bits. Arithmetic and compare immediates are widened with sign extension, which copies the immediate's top bit into all sixteen upper bits. Logical immediates are widened with zero extension.

A single modulo-2^32 adder does the work for all arithmetic and compare operations. Subtraction is formed as the first operand plus the inverted second operand with a carry-in of one. Less-than comparisons are derived from that same subtraction, using its sign, its overflow and its carry-out.

Top module: `ieu_exec`

Operation codes on `op_i` (5 bits, decimal):

| Code | Operation | Code | Operation |
|------|-----------|------|-----------|
| 0 | ADD | 9 | NOR |
| 1 | ADDU | 10 | ADDI |
| 2 | SUB | 11 | ADDIU |
| 3 | SUBU | 12 | SLTI |
| 4 | SLT | 13 | SLTIU |
| 5 | SLTU | 14 | ANDI |
| 6 | AND | 15 | ORI |
| 7 | OR | 16 | XORI |
| 8 | XOR | 17–31 | unknown |

## Requirements
- R1: For codes 0 (ADD) and 1 (ADDU), `result_o` equals `rs_i + rt_i` modulo 2^32.
- R2: For codes 2 (SUB) and 3 (SUBU), `result_o` equals `rs_i - rt_i` modulo 2^32.
- R3: `ovf_o` may be 1 only for codes 0, 2 and 10, and only when signed overflow occurs.
  - For ADD and ADDI, overflow means both addends share a sign and the sum's sign differs from it.
  - For SUB, overflow means `rs_i` and `rt_i` differ in sign and the result's sign differs from `rs_i`.
  - Every other code drives `ovf_o` to 0.
- R4: For codes 10 (ADDI) and 11 (ADDIU), `result_o` equals `rs_i` plus the sign-extended `imm_i` (bit 15 copied into bits 31:16), modulo 2^32.
- R5: For code 4 (SLT), `result_o` is 1 when `rs_i < rt_i` as signed numbers and 0 otherwise. Code 5 (SLTU) does the same with an unsigned comparison. In both cases bits 31:1 are always 0.
- R6: For codes 12 (SLTI) and 13 (SLTIU), the second operand of the comparison is the sign-extended `imm_i`. SLTI compares signed and SLTIU compares unsigned.
- R7: For codes 6, 7, 8 and 9, `result_o` is the bitwise AND, OR, XOR or NOR of `rs_i` and `rt_i`.
- R8: For codes 14 (ANDI), 15 (ORI) and 16 (XORI), the second operand is `imm_i` zero-extended to 32 bits. ORI with `rs_i` = 0 and `imm_i` = 15 gives exactly 15.
- R9: For codes 17 to 31, `result_o` is 0 and `ovf_o` is 0.
- R10: Register forms ignore `imm_i`, and immediate forms ignore `rt_i`. Changing the ignored input leaves both outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Decoded operation code |
| rs_i | input | 32 | First register operand |
| rt_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The checker uses immediate assertions inside a combinational process. These assertions assume that all four inputs change together and hold known, two-state values whenever the outputs are evaluated. Under that assumption, no half-updated input set can be observed as a violation.

The bench respects this assumption. It drives `op_i`, `rs_i`, `rt_i` and `imm_i` in one concatenated assignment on the falling clock edge. It then waits for the outputs to settle before comparing them. Every opcode it applies is either defined or chosen deliberately from the unknown range.

// File: rtl/ieu_pkg.sv
package ieu_pkg;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 16;
  localparam int OP_W   = 5;

  typedef logic [OP_W-1:0] op_t;

  localparam op_t OP_ADD   = 5'd0;
  localparam op_t OP_ADDU  = 5'd1;
  localparam op_t OP_SUB   = 5'd2;
  localparam op_t OP_SUBU  = 5'd3;
  localparam op_t OP_SLT   = 5'd4;
  localparam op_t OP_SLTU  = 5'd5;
  localparam op_t OP_AND   = 5'd6;
  localparam op_t OP_OR    = 5'd7;
  localparam op_t OP_XOR   = 5'd8;
  localparam op_t OP_NOR   = 5'd9;
  localparam op_t OP_ADDI  = 5'd10;
  localparam op_t OP_ADDIU = 5'd11;
  localparam op_t OP_SLTI  = 5'd12;
  localparam op_t OP_SLTIU = 5'd13;
  localparam op_t OP_ANDI  = 5'd14;
  localparam op_t OP_ORI   = 5'd15;
  localparam op_t OP_XORI  = 5'd16;

  typedef enum logic [1:0] {RES_NONE, RES_ARITH, RES_SLT, RES_LOGIC} res_sel_e;
  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_NOR} lg_fn_e;

  typedef struct packed {
    logic     use_imm;
    logic     imm_sext;
    logic     sub;
    logic     ovf_en;
    logic     cmp_signed;
    res_sel_e sel;
    lg_fn_e   lfn;
  } ctrl_t;
endpackage

// File: rtl/ieu_decode.sv
module ieu_decode
  import ieu_pkg::*;
(
  input  op_t   op_i,
  output ctrl_t ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    ctrl_o.sel = RES_NONE;
    ctrl_o.lfn = LG_AND;
    unique case (op_i)
      OP_ADD:   begin ctrl_o.sel = RES_ARITH; ctrl_o.ovf_en = 1'b1; end
      OP_ADDU:  begin ctrl_o.sel = RES_ARITH; end
      OP_SUB:   begin ctrl_o.sel = RES_ARITH; ctrl_o.sub = 1'b1; ctrl_o.ovf_en = 1'b1; end
      OP_SUBU:  begin ctrl_o.sel = RES_ARITH; ctrl_o.sub = 1'b1; end
      OP_SLT:   begin ctrl_o.sel = RES_SLT; ctrl_o.sub = 1'b1; ctrl_o.cmp_signed = 1'b1; end
      OP_SLTU:  begin ctrl_o.sel = RES_SLT; ctrl_o.sub = 1'b1; end
      OP_AND:   begin ctrl_o.sel = RES_LOGIC; ctrl_o.lfn = LG_AND; end
      OP_OR:    begin ctrl_o.sel = RES_LOGIC; ctrl_o.lfn = LG_OR; end
      OP_XOR:   begin ctrl_o.sel = RES_LOGIC; ctrl_o.lfn = LG_XOR; end
      OP_NOR:   begin ctrl_o.sel = RES_LOGIC; ctrl_o.lfn = LG_NOR; end
      OP_ADDI:  begin
        ctrl_o.sel = RES_ARITH; ctrl_o.use_imm = 1'b1; ctrl_o.imm_sext = 1'b1;
        ctrl_o.ovf_en = 1'b1;
      end
      OP_ADDIU: begin ctrl_o.sel = RES_ARITH; ctrl_o.use_imm = 1'b1; ctrl_o.imm_sext = 1'b1; end
      OP_SLTI:  begin
        ctrl_o.sel = RES_SLT; ctrl_o.use_imm = 1'b1; ctrl_o.imm_sext = 1'b1;
        ctrl_o.sub = 1'b1; ctrl_o.cmp_signed = 1'b1;
      end
      OP_SLTIU: begin
        ctrl_o.sel = RES_SLT; ctrl_o.use_imm = 1'b1; ctrl_o.imm_sext = 1'b1;
        ctrl_o.sub = 1'b1;
      end
      OP_ANDI:  begin ctrl_o.sel = RES_LOGIC; ctrl_o.use_imm = 1'b1; ctrl_o.lfn = LG_AND; end
      OP_ORI:   begin ctrl_o.sel = RES_LOGIC; ctrl_o.use_imm = 1'b1; ctrl_o.lfn = LG_OR; end
      OP_XORI:  begin ctrl_o.sel = RES_LOGIC; ctrl_o.use_imm = 1'b1; ctrl_o.lfn = LG_XOR; end
      default:  ctrl_o.sel = RES_NONE;
    endcase
  end
endmodule

// File: rtl/ieu_operand.sv
module ieu_operand #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              use_imm_i,
  input  logic              sext_i,
  input  logic [DATA_W-1:0] rt_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] opb_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [EXT_W-1:0] ext_bits;

  assign ext_bits = sext_i ? {EXT_W{imm_i[IMM_W-1]}} : '0;
  assign opb_o    = use_imm_i ? {ext_bits, imm_i} : rt_i;
endmodule

// File: rtl/ieu_adder.sv
module ieu_adder #(
  parameter int DATA_W = 32
) (
  input  logic              sub_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              ovf_o,
  output logic              lt_s_o,
  output logic              lt_u_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  assign b_eff = sub_i ? ~b_i : b_i;
  // carry-in of one completes the two's complement of b for subtraction
  assign wide  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
  assign sum_o = wide[MSB:0];
  assign ovf_o = (a_i[MSB] == b_eff[MSB]) && (wide[MSB] != a_i[MSB]);
  assign lt_s_o = wide[MSB] ^ ovf_o;
  assign lt_u_o = ~wide[DATA_W];
endmodule

// File: rtl/ieu_logic.sv
module ieu_logic
  import ieu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  lg_fn_e            fn_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    unique case (fn_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/ieu_exec.sv
module ieu_exec
  import ieu_pkg::*;
#(
  parameter int DATA_W = ieu_pkg::DATA_W,
  parameter int IMM_W  = ieu_pkg::IMM_W
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ovf_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] lg_y;
  logic              add_ovf;
  logic              lt_s;
  logic              lt_u;
  logic              lt_sel;

  ieu_decode u_decode (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  ieu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_operand (
    .use_imm_i (ctrl.use_imm),
    .sext_i    (ctrl.imm_sext),
    .rt_i      (rt_i),
    .imm_i     (imm_i),
    .opb_o     (opb)
  );

  ieu_adder #(.DATA_W(DATA_W)) u_adder (
    .sub_i  (ctrl.sub),
    .a_i    (rs_i),
    .b_i    (opb),
    .sum_o  (sum),
    .ovf_o  (add_ovf),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  ieu_logic #(.DATA_W(DATA_W)) u_logic (
    .fn_i (ctrl.lfn),
    .a_i  (rs_i),
    .b_i  (opb),
    .y_o  (lg_y)
  );

  assign lt_sel = ctrl.cmp_signed ? lt_s : lt_u;

  always_comb begin
    unique case (ctrl.sel)
      RES_ARITH: result_o = sum;
      RES_SLT:   result_o = {{(DATA_W-1){1'b0}}, lt_sel};
      RES_LOGIC: result_o = lg_y;
      default:   result_o = '0;
    endcase
  end

  assign ovf_o = ctrl.ovf_en & add_ovf;
endmodule

// File: rtl/ieu_exec_chk.sv
module ieu_exec_chk
  import ieu_pkg::*;
#(
  parameter int DATA_W = ieu_pkg::DATA_W,
  parameter int IMM_W  = ieu_pkg::IMM_W
) (
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] rs_i,
  input logic [DATA_W-1:0] rt_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [DATA_W-1:0] result_o,
  input logic              ovf_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  always_comb begin
    if (op_i == OP_ADD || op_i == OP_ADDU)
      assert_add_sum_R1: assert (result_o == rs_i + rt_i);
    if (!(op_i == OP_ADD || op_i == OP_SUB || op_i == OP_ADDI))
      assert_no_overflow_R3: assert (!ovf_o);
    if (op_i == OP_SLT || op_i == OP_SLTU || op_i == OP_SLTI || op_i == OP_SLTIU)
      assert_slt_bool_R5: assert (result_o[DATA_W-1:1] == '0);
    if (op_i == OP_ORI)
      assert_ori_zext_R8: assert (result_o == (rs_i | {{EXT_W{1'b0}}, imm_i}));
    if (op_i > OP_XORI)
      assert_unknown_zero_R9: assert (result_o == '0 && !ovf_o);
  end
endmodule

bind ieu_exec ieu_exec_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .op_i     (op_i),
  .rs_i     (rs_i),
  .rt_i     (rt_i),
  .imm_i    (imm_i),
  .result_o (result_o),
  .ovf_o    (ovf_o)
);

// File: tb/ieu_exec_tb.sv
module ieu_exec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op = 5'd31;
  logic [31:0] rs = '0;
  logic [31:0] rt = '0;
  logic [15:0] imm = '0;
  logic [31:0] result;
  logic        ovf;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  ieu_exec u_dut (
    .op_i     (op),
    .rs_i     (rs),
    .rt_i     (rt),
    .imm_i    (imm),
    .result_o (result),
    .ovf_o    (ovf)
  );

  task automatic drive(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] i);
    @(negedge clk);
    {op, rs, rt, imm} = {o, a, b, i};
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] exp_r, input logic exp_o);
    n_chk++;
    if (result !== exp_r || ovf !== exp_o) begin
      n_bad++;
      $display("FAIL %s: op=%0d result=%h ovf=%b expected result=%h ovf=%b",
               req, op, result, ovf, exp_r, exp_o);
    end
  endtask

  task automatic t_idle();
    drive(5'd31, 32'h0, 32'h0, 16'h0);
    chk("R9 idle", 32'h0, 1'b0);
    drive(5'd0, 32'h0, 32'h0, 16'h0);
    chk("R1 zero", 32'h0, 1'b0);
  endtask

  task automatic t_add_R1();
    drive(5'd0, 32'd15, 32'd7, 16'h0);        chk("R1 add", 32'd22, 1'b0);
    drive(5'd1, 32'hFFFF_FFFF, 32'd1, 16'h0); chk("R1 addu wrap", 32'h0, 1'b0);
    drive(5'd0, 32'hFFFF_FFFF, 32'd1, 16'h0); chk("R1 add -1+1", 32'h0, 1'b0);
    drive(5'd0, 32'h7FFF_FFFF, 32'd1, 16'h0); chk("R3 add ovf", 32'h8000_0000, 1'b1);
    drive(5'd0, 32'h8000_0000, 32'h8000_0000, 16'h0); chk("R3 add neg ovf", 32'h0, 1'b1);
    drive(5'd1, 32'h7FFF_FFFF, 32'd1, 16'h0); chk("R3 addu no ovf", 32'h8000_0000, 1'b0);
  endtask

  task automatic t_sub_R2();
    drive(5'd2, 32'd5, 32'd7, 16'h0);         chk("R2 sub", 32'hFFFF_FFFE, 1'b0);
    drive(5'd3, 32'd100, 32'd58, 16'h0);      chk("R2 subu", 32'd42, 1'b0);
    drive(5'd2, 32'h8000_0000, 32'd1, 16'h0); chk("R3 sub ovf", 32'h7FFF_FFFF, 1'b1);
    drive(5'd3, 32'h8000_0000, 32'd1, 16'h0); chk("R3 subu no ovf", 32'h7FFF_FFFF, 1'b0);
    drive(5'd2, 32'd0, 32'h8000_0000, 16'h0); chk("R3 sub 0-min ovf", 32'h8000_0000, 1'b1);
  endtask

  task automatic t_addi_R4();
    drive(5'd10, 32'd10, 32'h0, 16'hFFFF);    chk("R4 addi -1", 32'd9, 1'b0);
    drive(5'd11, 32'd0, 32'h0, 16'h8000);     chk("R4 addiu sext", 32'hFFFF_8000, 1'b0);
    drive(5'd10, 32'd15, 32'h0, 16'd7);       chk("R4 addi +7", 32'd22, 1'b0);
    drive(5'd10, 32'h7FFF_FFFF, 32'h0, 16'd1); chk("R3 addi ovf", 32'h8000_0000, 1'b1);
    drive(5'd11, 32'h7FFF_FFFF, 32'h0, 16'd1); chk("R3 addiu no ovf", 32'h8000_0000, 1'b0);
  endtask

  task automatic t_slt_R5();
    drive(5'd4, 32'hFFFF_FFFF, 32'd1, 16'h0); chk("R5 slt -1<1", 32'd1, 1'b0);
    drive(5'd5, 32'hFFFF_FFFF, 32'd1, 16'h0); chk("R5 sltu big", 32'd0, 1'b0);
    drive(5'd4, 32'd9, 32'd9, 16'h0);         chk("R5 slt equal", 32'd0, 1'b0);
    drive(5'd4, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0); chk("R5 slt min<max", 32'd1, 1'b0);
    drive(5'd4, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0); chk("R5 slt max>min", 32'd0, 1'b0);
    drive(5'd5, 32'd3, 32'd4, 16'h0);         chk("R5 sltu 3<4", 32'd1, 1'b0);
  endtask

  task automatic t_slti_R6();
    drive(5'd12, 32'd0, 32'h0, 16'hFFFF);     chk("R6 slti 0<-1", 32'd0, 1'b0);
    drive(5'd12, 32'hFFFF_FFFE, 32'h0, 16'hFFFF); chk("R6 slti -2<-1", 32'd1, 1'b0);
    drive(5'd13, 32'd5, 32'h0, 16'hFFFF);     chk("R6 sltiu vs all-ones", 32'd1, 1'b0);
    drive(5'd13, 32'hFFFF_8001, 32'h0, 16'h8000); chk("R6 sltiu above", 32'd0, 1'b0);
  endtask

  task automatic t_logic_R7();
    drive(5'd6, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0); chk("R7 and", 32'hF000_1200, 1'b0);
    drive(5'd7, 32'hF0F0_1234, 32'h0F00_0001, 16'h0); chk("R7 or", 32'hFFF0_1235, 1'b0);
    drive(5'd8, 32'hAAAA_5555, 32'hFFFF_0000, 16'h0); chk("R7 xor", 32'h5555_5555, 1'b0);
    drive(5'd9, 32'h0000_00F0, 32'h0F00_000F, 16'h0); chk("R7 nor", 32'hF0FF_FF00, 1'b0);
  endtask

  task automatic t_logimm_R8();
    drive(5'd15, 32'd0, 32'h0, 16'd15);       chk("R8 ori zero 15", 32'd15, 1'b0);
    drive(5'd14, 32'hFFFF_FFFF, 32'h0, 16'h8000); chk("R8 andi zext", 32'h0000_8000, 1'b0);
    drive(5'd16, 32'hFFFF_0000, 32'h0, 16'h8001); chk("R8 xori zext", 32'hFFFF_8001, 1'b0);
    drive(5'd15, 32'h1234_0000, 32'h0, 16'hFFFF); chk("R8 ori upper", 32'h1234_FFFF, 1'b0);
  endtask

  task automatic t_unknown_R9();
    drive(5'd17, 32'h7FFF_FFFF, 32'd1, 16'hFFFF); chk("R9 op17", 32'h0, 1'b0);
    drive(5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF); chk("R9 op31", 32'h0, 1'b0);
  endtask

  task automatic t_ignore_R10();
    drive(5'd0, 32'd100, 32'd23, 16'hFFFF);   chk("R10 add ignores imm", 32'd123, 1'b0);
    drive(5'd7, 32'h0, 32'h0, 16'hABCD);      chk("R10 or ignores imm", 32'h0, 1'b0);
    drive(5'd10, 32'd100, 32'hDEAD_BEEF, 16'd23); chk("R10 addi ignores rt", 32'd123, 1'b0);
    drive(5'd14, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h00F0); chk("R10 andi ignores rt", 32'h0000_00F0, 1'b0);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_add_R1();
    t_sub_R2();
    t_addi_R4();
    t_slt_R5();
    t_slti_R6();
    t_logic_R7();
    t_logimm_R8();
    t_unknown_R9();
    t_ignore_R10();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule